// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Start-Up Sequencing

This block keeps a two-bank DRAM array alive and brings it out of power-up in a legal way. When reset is released it first holds every strobe inactive for a long settling pause. It then runs a fixed number of CAS-before-RAS refresh cycles to prime the devices' internal row counters. Only after the last of these has finished its precharge does it raise `ready`. From then on it raises a refresh request at a fixed interval. When the access sequencer grants the bus, it drives one CAS-before-RAS cycle on all banks at once.

No address is produced, because the devices step their own row counter on every CAS-before-RAS cycle. Write enable is held inactive throughout, so the devices see no write during a refresh. All timing is given in nanoseconds and converted into clock cycles from the clock frequency, rounding up. At the default 100 MHz this gives a 20000-cycle pause, a 1500-cycle refresh interval (15 µs against a 15.6 µs average budget), and an 11-cycle refresh made of 1 cycle CAS lead, 6 cycles RAS low and 4 cycles precharge.

A request that is not yet granted stays pending. If a second interval ends while one is still pending, a sticky overflow flag is raised, which only reset clears.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted and during the power-up pause, `ready`, `ref_req`, `overflow` and `ref_busy` are low, and every `ras_n` and `cas_n` bit is high.
- R2: The first CAS falling edge after reset release comes exactly PAUSE cycles after the first clock edge that sees reset released. PAUSE is ceil(PAUSE_NS·CLK_MHZ/1000).
- R3: After the pause, WARMUP CAS-before-RAS cycles run back to back, separated by one idle cycle, with no grant needed. `ready` rises in the cycle that follows the final precharge cycle of the last one, and then stays high until reset.
- R4: Each refresh cycle runs CSR cycles with CAS low and RAS high, then RAS_C cycles with both low, then PRE cycles with both high. All banks carry identical strobes.
- R5: `we_n` is high in every cycle, so it is high before, during and after every CAS low period.
- R6: Once `ready` is high, an interval tick occurs every INTERVAL cycles, the first one INTERVAL cycles after `ready` rises. `ref_req` goes high in the cycle after a tick.
- R7: In the cycle after a clock edge that sees `ref_req`, `ref_gnt` and not `ref_busy`, the CAS lead phase begins, `ref_busy` is high, and `ref_req` is low unless a tick happened at the same edge.
- R8: `ref_gnt` has no effect while no request is pending, including during the pause and warm-up. No refresh starts and the strobes stay high.
- R9: `overflow` is set when an interval tick happens while a request is still pending and not being granted at that edge. It then stays high until reset.
- R10: `ref_busy` is high exactly in the cycles in which a refresh cycle (lead, RAS low or precharge) is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Bus granted to the refresh engine by the access sequencer |
| ref_req | output | 1 | Refresh pending, bus wanted |
| ready | output | 1 | Start-up sequence complete, normal accesses allowed |
| overflow | output | 1 | Sticky: an interval ended with a request still pending |
| ref_busy | output | 1 | Refresh engine owns the DRAM strobes this cycle |
| ras_n | output | NBANK | Row strobe, one per bank, active low |
| cas_n | output | NBANK | Column strobe, one per bank, active low |
| we_n | output | 1 | Write enable, active low, held high |

## Verification
The assertions take `ref_gnt` to be a synchronous level that may take any value in any cycle, with or without a pending request. They also take reset to be released away from the active edge. Because of this, the request-to-start and no-request-no-start properties need no assumption about how the sequencer behaves. The stimulus changes `ref_gnt` and `rst_n` only on the falling clock edge. It covers grant held high, grant withheld for longer than two intervals, pseudo-random grant, and grant driven only while nothing is pending, plus a reset in the middle of operation.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

  typedef enum logic [1:0] {
    MODE_PAUSE = 2'd0,
    MODE_WARM  = 2'd1,
    MODE_RUN   = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_ROW  = 2'd2,
    PH_PRE  = 2'd3
  } phase_e;

  // Round a duration in ns up to whole clock cycles, minimum one.
  function automatic int ns_to_cyc(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  // Counter width able to hold the value n.
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rfs_cbr_gen.sv
module rfs_cbr_gen
  import refresh_sched_pkg::*;
#(
  parameter int LEAD_CYC = 1,
  parameter int ROW_CYC  = 6,
  parameter int PRE_CYC  = 4,
  parameter int NBANK    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [NBANK-1:0] ras_n,
  output logic [NBANK-1:0] cas_n
);

  localparam int CW = cnt_w(max3(LEAD_CYC, ROW_CYC, PRE_CYC));
  localparam logic [CW-1:0] LEAD_LAST = CW'(LEAD_CYC - 1);
  localparam logic [CW-1:0] ROW_LAST  = CW'(ROW_CYC - 1);
  localparam logic [CW-1:0] PRE_LAST  = CW'(PRE_CYC - 1);

  phase_e        ph;
  logic [CW-1:0] cnt;
  logic          seg_end;
  logic          row_low;
  logic          col_low;

  always_comb begin
    unique case (ph)
      PH_LEAD: seg_end = (cnt == LEAD_LAST);
      PH_ROW:  seg_end = (cnt == ROW_LAST);
      PH_PRE:  seg_end = (cnt == PRE_LAST);
      default: seg_end = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          if (start) begin
            ph  <= PH_LEAD;
            cnt <= '0;
          end
        end
        PH_LEAD: begin
          if (seg_end) begin
            ph  <= PH_ROW;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_ROW: begin
          if (seg_end) begin
            ph  <= PH_PRE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_PRE: begin
          if (seg_end) begin
            ph  <= PH_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          ph  <= PH_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

  assign busy    = (ph != PH_IDLE);
  assign done    = (ph == PH_PRE) && seg_end;
  assign row_low = (ph == PH_ROW);
  assign col_low = (ph == PH_LEAD) || (ph == PH_ROW);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign ras_n[b] = ~row_low;
    assign cas_n[b] = ~col_low;
  end

endmodule

// File: rtl/rfs_interval.sv
module rfs_interval
  import refresh_sched_pkg::*;
#(
  parameter int INT_CYC = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int TW = cnt_w(INT_CYC);
  localparam logic [TW-1:0] T_LAST = TW'(INT_CYC - 1);

  logic [TW-1:0] tcnt;

  assign tick = run && (tcnt == T_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
    end else if (!run || tick) begin
      tcnt <= '0;
    end else begin
      tcnt <= tcnt + 1'b1;
    end
  end

endmodule

// File: rtl/rfs_ctrl.sv
module rfs_ctrl
  import refresh_sched_pkg::*;
#(
  parameter int PAUSE_CYC = 20000,
  parameter int WARMUP    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_gnt,
  input  logic gen_busy,
  input  logic gen_done,
  input  logic tick,
  output logic start,
  output logic warm_start,
  output logic run_start,
  output logic run,
  output logic ready,
  output logic ref_req,
  output logic overflow
);

  localparam int PW = cnt_w(PAUSE_CYC);
  localparam int WW = cnt_w(WARMUP);
  localparam logic [PW-1:0] P_LAST = PW'(PAUSE_CYC - 1);
  localparam logic [WW-1:0] W_LAST = WW'(WARMUP - 1);

  mode_e         mode;
  logic [PW-1:0] pcnt;
  logic [WW-1:0] wcnt;
  logic          pend;
  logic          ovf;

  assign run        = (mode == MODE_RUN);
  assign warm_start = (mode == MODE_WARM) && !gen_busy;
  assign run_start  = run && pend && ref_gnt && !gen_busy;
  assign start      = warm_start || run_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MODE_PAUSE;
      pcnt <= '0;
      wcnt <= '0;
    end else begin
      unique case (mode)
        MODE_PAUSE: begin
          if (pcnt == P_LAST) mode <= MODE_WARM;
          else                pcnt <= pcnt + 1'b1;
        end
        MODE_WARM: begin
          if (gen_done) begin
            wcnt <= wcnt + 1'b1;
            if (wcnt == W_LAST) mode <= MODE_RUN;
          end
        end
        default: mode <= MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      pend <= tick || (pend && !run_start);
      ovf  <= ovf || (tick && pend && !run_start);
    end
  end

  assign ready    = run;
  assign ref_req  = pend;
  assign overflow = ovf;

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int PAUSE_NS    = 200000,
  parameter int INTERVAL_NS = 15000,
  parameter int CSR_NS      = 5,
  parameter int RAS_NS      = 60,
  parameter int RP_NS       = 40,
  parameter int WARMUP      = 8,
  parameter int NBANK       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             ready,
  output logic             overflow,
  output logic             ref_busy,
  output logic [NBANK-1:0] ras_n,
  output logic [NBANK-1:0] cas_n,
  output logic             we_n
);

  localparam int PAUSE_CYC = ns_to_cyc(PAUSE_NS, CLK_MHZ);
  localparam int INT_CYC   = ns_to_cyc(INTERVAL_NS, CLK_MHZ);
  localparam int LEAD_CYC  = ns_to_cyc(CSR_NS, CLK_MHZ);
  localparam int ROW_CYC   = ns_to_cyc(RAS_NS, CLK_MHZ);
  localparam int PRE_CYC   = ns_to_cyc(RP_NS, CLK_MHZ);

  logic start;
  logic warm_start;
  logic run_start;
  logic run;
  logic tick;
  logic gen_busy;
  logic gen_done;

  rfs_ctrl #(
    .PAUSE_CYC (PAUSE_CYC),
    .WARMUP    (WARMUP)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_gnt    (ref_gnt),
    .gen_busy   (gen_busy),
    .gen_done   (gen_done),
    .tick       (tick),
    .start      (start),
    .warm_start (warm_start),
    .run_start  (run_start),
    .run        (run),
    .ready      (ready),
    .ref_req    (ref_req),
    .overflow   (overflow)
  );

  rfs_interval #(
    .INT_CYC (INT_CYC)
  ) u_interval (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (tick)
  );

  rfs_cbr_gen #(
    .LEAD_CYC (LEAD_CYC),
    .ROW_CYC  (ROW_CYC),
    .PRE_CYC  (PRE_CYC),
    .NBANK    (NBANK)
  ) u_gen (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (gen_busy),
    .done  (gen_done),
    .ras_n (ras_n),
    .cas_n (cas_n)
  );

  assign ref_busy = gen_busy;
  assign we_n     = 1'b1;

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int ROW_CYC = 6,
  parameter int PRE_CYC = 4,
  parameter int NBANK   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_gnt,
  input logic             ref_req,
  input logic             ready,
  input logic             overflow,
  input logic             ref_busy,
  input logic [NBANK-1:0] ras_n,
  input logic [NBANK-1:0] cas_n
);

  int lo_cnt;
  int hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= 0;
      hi_cnt <= PRE_CYC;
    end else begin
      if (!ras_n[0]) begin
        hi_cnt <= 0;
        if (lo_cnt < ROW_CYC) lo_cnt <= lo_cnt + 1;
      end else begin
        lo_cnt <= 0;
        if (hi_cnt < PRE_CYC) hi_cnt <= hi_cnt + 1;
      end
    end
  end

  // R1
  not_ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (!ref_req && !overflow));

  // R3
  ready_rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (!ref_busy && (&ras_n) && (&cas_n)));

  // R4
  cas_leads_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n[0]) |-> $past(!cas_n[0]));

  // R4
  row_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n[0]) |-> (lo_cnt >= ROW_CYC));

  // R4
  precharge_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n[0]) |-> (hi_cnt >= PRE_CYC));

  // R7
  grant_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt && !ref_busy) |=> (ref_busy && !cas_n[0] && ras_n[0]));

  // R8
  no_req_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !ref_req && !ref_busy) |=> !ref_busy);

  // R9
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

endmodule

bind refresh_sched refresh_sched_chk #(
  .ROW_CYC (ROW_CYC),
  .PRE_CYC (PRE_CYC),
  .NBANK   (NBANK)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ref_gnt  (ref_gnt),
  .ref_req  (ref_req),
  .ready    (ready),
  .overflow (overflow),
  .ref_busy (ref_busy),
  .ras_n    (ras_n),
  .cas_n    (cas_n)
);

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;

  localparam int NB     = 2;
  localparam int PAUSE  = 50;   // 500 ns at 100 MHz setting
  localparam int INTV   = 40;   // 400 ns
  localparam int LEAD   = 1;    // 5 ns rounded up
  localparam int ROWC   = 6;    // 60 ns
  localparam int PREC   = 4;    // 40 ns
  localparam int TOT    = LEAD + ROWC + PREC;
  localparam int NWARM  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_gnt = 1'b0;
  logic          ref_req, ready, overflow, ref_busy, we_n;
  logic [NB-1:0] ras_n, cas_n;

  always #4 clk = ~clk;

  refresh_sched #(
    .CLK_MHZ     (100),
    .PAUSE_NS    (500),
    .INTERVAL_NS (400),
    .WARMUP      (NWARM),
    .NBANK       (NB)
  ) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_gnt  (ref_gnt),
    .ref_req  (ref_req),
    .ready    (ready),
    .overflow (overflow),
    .ref_busy (ref_busy),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n)
  );

  // Behavioural reference model
  int m_mode;      // 0 pause, 1 warm-up, 2 running
  int m_pcnt, m_wcnt, m_t, m_tcnt;
  bit m_pend, m_ovf, m_last_run;
  bit r8_phase;
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_pcnt = 0; m_wcnt = 0; m_t = -1; m_tcnt = 0;
      m_pend = 0; m_ovf = 0; m_last_run = 0;
    end else begin
      bit st_w, st_r, dn, tk;
      st_w = (m_mode == 1) && (m_t < 0);
      st_r = (m_mode == 2) && m_pend && ref_gnt && (m_t < 0);
      dn   = (m_t == TOT - 1);
      tk   = (m_mode == 2) && (m_tcnt == INTV - 1);
      m_last_run = st_r;
      m_ovf  = m_ovf || (tk && m_pend && !st_r);
      m_pend = tk || (m_pend && !st_r);
      m_tcnt = (m_mode == 2) ? (tk ? 0 : m_tcnt + 1) : 0;
      if (st_w || st_r) m_t = 0;
      else if (m_t >= 0) m_t = dn ? -1 : m_t + 1;
      if (m_mode == 0) begin
        if (m_pcnt == PAUSE - 1) m_mode = 1;
        else m_pcnt++;
      end else if (m_mode == 1 && dn) begin
        m_wcnt++;
        if (m_wcnt == NWARM) m_mode = 2;
      end
    end
  end

  task automatic chk(input string tag, input string sig, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, sig, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [NB-1:0] e_ras, e_cas;
    string st;
    bit act_cyc;
    act_cyc = (m_t >= 0);
    e_cas = (act_cyc && m_t < LEAD + ROWC) ? '0 : '1;
    e_ras = (m_t >= LEAD && m_t < LEAD + ROWC) ? '0 : '1;
    st = r8_phase ? "R8" : ((m_mode == 0) ? "R2" : "R4");
    chk(st, "cas_n", 32'(cas_n), 32'(e_cas));
    chk(st, "ras_n", 32'(ras_n), 32'(e_ras));
    chk((m_mode == 0) ? "R1" : "R3", "ready", 32'(ready), 32'(m_mode == 2));
    chk("R6", "ref_req", 32'(ref_req), 32'(m_pend));
    chk("R9", "overflow", 32'(overflow), 32'(m_ovf));
    chk(m_last_run ? "R7" : "R10", "ref_busy", 32'(ref_busy), 32'(act_cyc));
    chk("R5", "we_n", 32'(we_n), 32'd1);
  endtask

  task automatic step(input logic g);
    @(negedge clk);
    compare_all();
    ref_gnt = g;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ref_gnt = 1'b1;          // R8: grant during reset and pause is ignored
    for (int i = 0; i < 3; i++) step(1'b1);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [7:0] lf;
    lf = 8'hA5;
    r8_phase = 0;
    for (int i = 0; i < 3; i++) step(1'b0);   // R1: reset state
    do_reset();
    // R2 / R3 / R8: pause and warm-up with grant held high
    for (int i = 0; i < PAUSE + NWARM * (TOT + 1) + 5; i++) step(1'b1);
    // R6 / R7: grant always available
    for (int i = 0; i < 300; i++) step(1'b1);
    // R9: grant withheld across more than two intervals
    for (int i = 0; i < 100; i++) step(1'b0);
    for (int i = 0; i < 60; i++) step(1'b1);
    // R7: pseudo-random grant
    for (int i = 0; i < 400; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      step(lf[1] | lf[5]);
    end
    // R1: reset in mid-operation clears overflow and pending request
    do_reset();
    for (int i = 0; i < PAUSE + NWARM * (TOT + 1) + 5; i++) step(1'b0);
    // R8: grant offered only while nothing is pending
    r8_phase = 1;
    for (int i = 0; i < 200; i++) step(!m_pend);
    r8_phase = 0;
    for (int i = 0; i < 20; i++) step(1'b1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule